// File: doc/BRIEF.md
# SDRAM Bank-State Command Checker

This block is a passive monitor placed beside an SDRAM command bus. Every clock it samples the chip select, row strobe, column strobe and write enable, the bank address and the row/column address, and decodes one command. It keeps a small state machine per bank and a global mode-load timer. When a command breaks a bank rule, it raises a one-cycle violation pulse with a reason code. It never drives the bus.

Each bank machine has four states. IDLE means no row is open. OPEN means a row is open and no burst is running. BURST means a read or write burst is in progress on the open row. PRECH means a precharge is counting down the precharge time. The transitions are:
- IDLE to OPEN on ACTIVE.
- OPEN to BURST on READ or WRITE.
- BURST back to OPEN when the burst ends without auto precharge, or on BURST TERMINATE.
- BURST to PRECH when a burst with auto precharge ends, or on an explicit PRECHARGE.
- OPEN to PRECH on PRECHARGE.
- PRECH to IDLE when the count expires, or directly to OPEN if an ACTIVE arrives on the first legal cycle.

A flagged command is dropped: it changes no bank state and starts no timer.

Top module: `sdram_cmd_checker`

## Requirements
- R1: After reset `viol_valid` is 0 and every bank reports IDLE. The per-bank 2-bit state on `bank_state` (bank b at bits 2b+1:2b) encodes IDLE=0, OPEN=1, BURST=2, PRECH=3.
- R2: ACTIVE (`{cs_n,ras_n,cas_n,we_n}`=0011) to an IDLE bank opens it and records `addr` as that bank's row on `bank_row` (bank b at bits 11b+10:11b). ACTIVE to a bank that is OPEN or in a burst without auto precharge is flagged with code 3.
- R3: READ (0101) or WRITE (0100) to a bank with no open row is flagged with code 4.
- R4: A READ or WRITE to an open bank holds BURST for `cfg_burst_len`/2 cycles. If `addr[8]` was 0, the bank then returns to OPEN. If `addr[8]` was 1, it enters PRECH.
- R5: PRECHARGE (0010) with `addr[8]`=1 sends every open bank to PRECH and ignores `ba`. With `addr[8]`=0 only bank `ba` is affected.
- R6: PRECHARGE to a bank that is IDLE or already precharging is not flagged and does not restart its count.
- R7: A bank in PRECH, or in a burst with auto precharge pending, rejects ACTIVE, READ and WRITE with code 2. Counting from the clock that entered PRECH, the command `cfg_trp` clocks later is accepted.
- R8: LOAD MODE (0000) is flagged with code 5 unless every bank is IDLE or has finished its precharge count.
- R9: After an accepted LOAD MODE, any command other than NOP or deselect within the next `cfg_tmrd`-1 clocks is flagged with code 1. This code takes priority over every other code.
- R10: BURST TERMINATE (0110) is accepted only while a read burst without auto precharge is running, and it returns that bank to OPEN. Otherwise it is flagged with code 6.
- R11: Deselect (`cs_n`=1, whatever the other strobes) and NOP (0111) are never flagged and leave all bank state unchanged.
- R12: The violation appears on the clock after the command is sampled, lasts one cycle per offending command, and the flagged command has no effect on bank state or rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 11 | Row address; column in bits 7:0; bit 8 selects auto or all-bank precharge |
| cfg_burst_len | input | 4 | Burst length 2, 4 or 8 |
| cfg_trp | input | 4 | Precharge time in clocks (0 is treated as 1) |
| cfg_tmrd | input | 4 | Mode-load recovery in clocks (0 is treated as 1) |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Reason: 0 none, 1 tMRD, 2 tRP/pending precharge, 3 row already open, 4 no open row, 5 mode load while busy, 6 illegal terminate |
| bank_state | output | 8 | Per-bank state, 2 bits each |
| bank_row | output | 44 | Per-bank open row, 11 bits each |

## Verification
The bench uses the default geometry: four banks and 11-bit rows. It sets the precharge time to 3 and the mode-load recovery to 2, so both the blocked cycles and the first accepted cycle fall inside short sequences. The burst length is first 4 and then 8, which exercises both a two-cycle and a four-cycle BURST hold before auto precharge. With the default widths, a single scoreboard entry per cycle can check codes, all four bank states and individual rows exactly.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_RD    = 3'd2,
        CMD_WR    = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_BST   = 3'd5,
        CMD_LMR   = 3'd6,
        CMD_OTHER = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_BURST = 2'd2,
        BK_PRECH = 2'd3
    } bank_st_e;

    typedef enum logic [2:0] {
        VC_NONE     = 3'd0,
        VC_TMRD     = 3'd1,
        VC_TRP      = 3'd2,
        VC_ACT_OPEN = 3'd3,
        VC_NO_ROW   = 3'd4,
        VC_MRS_BUSY = 3'd5,
        VC_BAD_BST  = 3'd6
    } viol_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b110:  cmd = CMD_BST;
                3'b000:  cmd = CMD_LMR;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sdram_tmrd_timer.sv
module sdram_tmrd_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cfg_tmrd,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;

    always_comb begin
        cnt_n = cnt_q;
        if (load) begin
            cnt_n = (cfg_tmrd == '0) ? '0 : cfg_tmrd - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_n = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_n;
    end

    assign busy = (cnt_q != '0);

    // R9
    tmrd_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_chk_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             rd_go,
    input  logic             wr_go,
    input  logic             pre_go,
    input  logic             bst_go,
    input  logic             ap,
    input  logic [ROW_W-1:0] row_in,
    input  logic [CNT_W-1:0] burst_cyc,
    input  logic [CNT_W-1:0] trp_cyc,
    output bank_st_e         state,
    output logic [ROW_W-1:0] row,
    output logic             blocked,
    output logic             eff_idle,
    output logic             is_open,
    output logic             rd_noap
);

    bank_st_e         st_q, st_n;
    logic [ROW_W-1:0] row_q, row_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             ap_q, ap_n;
    logic             rd_q, rd_n;

    // next-state process
    always_comb begin
        st_n  = st_q;
        row_n = row_q;
        cnt_n = cnt_q;
        ap_n  = ap_q;
        rd_n  = rd_q;
        unique case (st_q)
            BK_IDLE: begin
                if (act_go) begin
                    st_n  = BK_OPEN;
                    row_n = row_in;
                end
            end
            BK_OPEN: begin
                if (pre_go) begin
                    st_n  = BK_PRECH;
                    cnt_n = trp_cyc - 1'b1;
                end else if (rd_go || wr_go) begin
                    st_n  = BK_BURST;
                    cnt_n = burst_cyc - 1'b1;
                    ap_n  = ap;
                    rd_n  = rd_go;
                end
            end
            BK_BURST: begin
                if (pre_go) begin
                    st_n  = BK_PRECH;
                    cnt_n = trp_cyc - 1'b1;
                end else if (bst_go) begin
                    st_n  = BK_OPEN;
                end else if (rd_go || wr_go) begin
                    cnt_n = burst_cyc - 1'b1;
                    ap_n  = ap;
                    rd_n  = rd_go;
                end else if (cnt_q == '0) begin
                    if (ap_q) begin
                        st_n  = BK_PRECH;
                        cnt_n = trp_cyc - 1'b1;
                    end else begin
                        st_n  = BK_OPEN;
                    end
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            BK_PRECH: begin
                if (act_go) begin
                    st_n  = BK_OPEN;
                    row_n = row_in;
                end else if (cnt_q == '0) begin
                    st_n  = BK_IDLE;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: st_n = BK_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            row_q <= '0;
            cnt_q <= '0;
            ap_q  <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            row_q <= row_n;
            cnt_q <= cnt_n;
            ap_q  <= ap_n;
            rd_q  <= rd_n;
        end
    end

    // output process
    always_comb begin
        state    = st_q;
        row      = row_q;
        blocked  = 1'b0;
        eff_idle = 1'b0;
        is_open  = 1'b0;
        rd_noap  = 1'b0;
        unique case (st_q)
            BK_IDLE:  eff_idle = 1'b1;
            BK_OPEN:  is_open  = 1'b1;
            BK_BURST: begin
                blocked = ap_q;
                is_open = !ap_q;
                rd_noap = !ap_q && rd_q;
            end
            BK_PRECH: begin
                blocked  = (cnt_q != '0);
                eff_idle = (cnt_q == '0);
            end
            default: eff_idle = 1'b0;
        endcase
    end

    // R7
    prech_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_PRECH && cnt_q != '0) |=> (st_q == BK_PRECH));

    // R4
    burst_noap_no_prech_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_BURST && !ap_q && !pre_go) |=> (st_q != BK_PRECH));

    // R2
    open_row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_OPEN || st_q == BK_BURST) |=> $stable(row_q));

    // R12
    go_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_go, rd_go, wr_go, pre_go, bst_go}));

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ROW_W  = 11,
    parameter int CNT_W  = 4,
    parameter int AP_BIT = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BA_W-1:0]           ba,
    input  logic [ROW_W-1:0]          addr,
    input  logic [CNT_W-1:0]          cfg_burst_len,
    input  logic [CNT_W-1:0]          cfg_trp,
    input  logic [CNT_W-1:0]          cfg_tmrd,
    output logic                      viol_valid,
    output logic [2:0]                viol_code,
    output logic [2*(1<<BA_W)-1:0]    bank_state,
    output logic [ROW_W*(1<<BA_W)-1:0] bank_row
);

    localparam int NB = 1 << BA_W;

    cmd_e             cmd;
    logic             mrd_busy;
    logic             mrd_load;
    logic [NB-1:0]    blocked_v, idle_v, open_v, rdb_v;
    logic [NB-1:0]    act_go, rd_go, wr_go, pre_go, bst_go;
    logic [CNT_W-1:0] burst_cyc, trp_cyc;
    logic             exec_cmd;
    logic             cmd_ok;
    viol_e            code_n;
    logic             vv_q;
    viol_e            vc_q;

    sdram_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_tmrd_timer #(.CNT_W(CNT_W)) u_tmrd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mrd_load),
        .cfg_tmrd (cfg_tmrd),
        .busy     (mrd_busy)
    );

    assign burst_cyc = ((cfg_burst_len >> 1) == '0) ? CNT_W'(1) : (cfg_burst_len >> 1);
    assign trp_cyc   = (cfg_trp == '0) ? CNT_W'(1) : cfg_trp;

    assign exec_cmd = (cmd == CMD_ACT) || (cmd == CMD_RD) || (cmd == CMD_WR) ||
                      (cmd == CMD_PRE) || (cmd == CMD_BST) || (cmd == CMD_LMR);

    // legality check, highest priority first
    always_comb begin
        code_n = VC_NONE;
        if (exec_cmd && mrd_busy) begin
            code_n = VC_TMRD;
        end else begin
            unique case (cmd)
                CMD_ACT: begin
                    if (blocked_v[ba])      code_n = VC_TRP;
                    else if (!idle_v[ba])   code_n = VC_ACT_OPEN;
                end
                CMD_RD, CMD_WR: begin
                    if (blocked_v[ba])      code_n = VC_TRP;
                    else if (!open_v[ba])   code_n = VC_NO_ROW;
                end
                CMD_BST: begin
                    if (rdb_v == '0)        code_n = VC_BAD_BST;
                end
                CMD_LMR: begin
                    if (!(&idle_v))         code_n = VC_MRS_BUSY;
                end
                default: code_n = VC_NONE;
            endcase
        end
    end

    assign cmd_ok   = (code_n == VC_NONE);
    assign mrd_load = cmd_ok && (cmd == CMD_LMR);

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            logic     sel;
            bank_st_e st;

            assign sel       = (ba == BA_W'(b));
            assign act_go[b] = cmd_ok && (cmd == CMD_ACT) && sel;
            assign rd_go[b]  = cmd_ok && (cmd == CMD_RD)  && sel;
            assign wr_go[b]  = cmd_ok && (cmd == CMD_WR)  && sel;
            assign pre_go[b] = cmd_ok && (cmd == CMD_PRE) && open_v[b] &&
                               (addr[AP_BIT] || sel);
            assign bst_go[b] = cmd_ok && (cmd == CMD_BST) && rdb_v[b];

            sdram_bank_fsm #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .act_go    (act_go[b]),
                .rd_go     (rd_go[b]),
                .wr_go     (wr_go[b]),
                .pre_go    (pre_go[b]),
                .bst_go    (bst_go[b]),
                .ap        (addr[AP_BIT]),
                .row_in    (addr),
                .burst_cyc (burst_cyc),
                .trp_cyc   (trp_cyc),
                .state     (st),
                .row       (bank_row[b*ROW_W +: ROW_W]),
                .blocked   (blocked_v[b]),
                .eff_idle  (idle_v[b]),
                .is_open   (open_v[b]),
                .rd_noap   (rdb_v[b])
            );

            assign bank_state[2*b +: 2] = st;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vv_q <= 1'b0;
            vc_q <= VC_NONE;
        end else begin
            vv_q <= !cmd_ok;
            vc_q <= code_n;
        end
    end

    assign viol_valid = vv_q;
    assign viol_code  = vc_q;

    // R11
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !viol_valid);

    // R9
    tmrd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_busy && exec_cmd) |=> (viol_valid && viol_code == VC_TMRD));

    // R8
    lmr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LMR && !mrd_busy && !(&idle_v)) |=> (viol_code == VC_MRS_BUSY));

    // R12
    code_matches_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid == (viol_code != VC_NONE));

endmodule

// File: tb/sdram_cmd_checker_bench.sv
module sdram_cmd_checker_bench;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_DES = 4'b1000;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_BST = 4'b0110;
    localparam logic [3:0] C_LMR = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [10:0] addr = '0;
    logic [3:0]  cfg_burst_len = 4'd4;
    logic [3:0]  cfg_trp = 4'd3;
    logic [3:0]  cfg_tmrd = 4'd2;
    logic        viol_valid;
    logic [2:0]  viol_code;
    logic [7:0]  bank_state;
    logic [43:0] bank_row;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0]  code;
        logic [7:0]  st;
        bit          chk_row;
        int          rbank;
        logic [10:0] row;
        string       req;
    } item_t;

    item_t exp_q[$];

    always #4 clk = ~clk;

    sdram_cmd_checker u_sdram_cmd_checker (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .we_n          (we_n),
        .ba            (ba),
        .addr          (addr),
        .cfg_burst_len (cfg_burst_len),
        .cfg_trp       (cfg_trp),
        .cfg_tmrd      (cfg_tmrd),
        .viol_valid    (viol_valid),
        .viol_code     (viol_code),
        .bank_state    (bank_state),
        .bank_row      (bank_row)
    );

    function automatic logic [7:0] st(int b3, int b2, int b1, int b0);
        return {b3[1:0], b2[1:0], b1[1:0], b0[1:0]};
    endfunction

    task automatic push_cmd(input logic [3:0] c, input logic [1:0] b,
                            input logic [10:0] a, input logic [2:0] code,
                            input logic [7:0] s, input bit cr, input int rb,
                            input logic [10:0] rv, input string req);
        item_t it;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba   = b;
        addr = a;
        it.code = code; it.st = s; it.chk_row = cr; it.rbank = rb;
        it.row = rv; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic issue(input logic [3:0] c, input logic [1:0] b,
                         input logic [10:0] a, input logic [2:0] code,
                         input logic [7:0] s, input string req);
        push_cmd(c, b, a, code, s, 1'b0, 0, '0, req);
    endtask

    task automatic issue_r(input logic [3:0] c, input logic [1:0] b,
                           input logic [10:0] a, input logic [2:0] code,
                           input logic [7:0] s, input int rb,
                           input logic [10:0] rv, input string req);
        push_cmd(c, b, a, code, s, 1'b1, rb, rv, req);
    endtask

    // monitor: compares one expected item per clock after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (viol_valid !== (it.code != 3'd0) || viol_code !== it.code) begin
                    fails++;
                    $display("FAIL %s: violation valid=%0b code=%0d, expected valid=%0b code=%0d",
                             it.req, viol_valid, viol_code, it.code != 3'd0, it.code);
                end
                checks++;
                if (bank_state !== it.st) begin
                    fails++;
                    $display("FAIL %s: bank_state=%h, expected %h", it.req, bank_state, it.st);
                end
                if (it.chk_row) begin
                    checks++;
                    if (bank_row[it.rbank*11 +: 11] !== it.row) begin
                        fails++;
                        $display("FAIL %s: bank%0d row=%h, expected %h", it.req, it.rbank,
                                 bank_row[it.rbank*11 +: 11], it.row);
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (viol_valid !== 1'b0 || bank_state !== 8'h00) begin
            fails++;
            $display("FAIL R1: valid=%0b state=%h, expected 0 and 00", viol_valid, bank_state);
        end
        issue  (C_NOP, 2'd0, 11'h000, 3'd0, st(0,0,0,0), "R1 idle after reset");
        issue  (C_DES, 2'd0, 11'h000, 3'd0, st(0,0,0,0), "R11 deselect");
        issue  (C_RD,  2'd0, 11'h000, 3'd4, st(0,0,0,0), "R3 read idle bank");
        issue_r(C_ACT, 2'd0, 11'h155, 3'd0, st(0,0,0,1), 0, 11'h155, "R2 activate");
        issue_r(C_ACT, 2'd0, 11'h2AA, 3'd3, st(0,0,0,1), 0, 11'h155, "R2 R12 activate open bank");
        issue  (C_ACT, 2'd1, 11'h007, 3'd0, st(0,0,1,1), "R2 activate bank1");
        issue  (C_LMR, 2'd0, 11'h000, 3'd5, st(0,0,1,1), "R8 mode load with open rows");
        issue  (C_WR,  2'd1, 11'h003, 3'd0, st(0,0,2,1), "R4 write burst start");
        issue  (C_NOP, 2'd0, 11'h000, 3'd0, st(0,0,2,1), "R4 burst second cycle");
        issue  (C_NOP, 2'd0, 11'h000, 3'd0, st(0,0,1,1), "R4 burst ends, row kept");
        issue  (C_RD,  2'd0, 11'h110, 3'd0, st(0,0,1,2), "R4 read with auto precharge");
        issue  (C_RD,  2'd0, 11'h000, 3'd2, st(0,0,1,2), "R7 read with precharge pending");
        issue  (C_NOP, 2'd0, 11'h000, 3'd0, st(0,0,1,3), "R4 auto precharge starts");
        issue  (C_ACT, 2'd0, 11'h0F0, 3'd2, st(0,0,1,3), "R7 activate inside tRP");
        issue  (C_PRE, 2'd0, 11'h000, 3'd0, st(0,0,1,3), "R6 precharge while precharging");
        issue_r(C_ACT, 2'd0, 11'h0F0, 3'd0, st(0,0,1,1), 0, 11'h0F0, "R7 activate at tRP");
        issue  (C_BST, 2'd0, 11'h000, 3'd6, st(0,0,1,1), "R10 terminate with no burst");
        issue  (C_RD,  2'd1, 11'h000, 3'd0, st(0,0,2,1), "R4 read burst bank1");
        issue  (C_BST, 2'd0, 11'h000, 3'd0, st(0,0,1,1), "R10 terminate read burst");
        issue  (C_WR,  2'd1, 11'h000, 3'd0, st(0,0,2,1), "R4 write burst bank1");
        issue  (C_BST, 2'd0, 11'h000, 3'd6, st(0,0,2,1), "R10 terminate write burst");
        issue  (C_PRE, 2'd3, 11'h100, 3'd0, st(0,0,3,3), "R5 precharge all");
        issue  (C_LMR, 2'd0, 11'h000, 3'd5, st(0,0,3,3), "R8 mode load during precharge");
        issue  (C_NOP, 2'd0, 11'h000, 3'd0, st(0,0,3,3), "R11 nop");
        issue  (C_LMR, 2'd0, 11'h000, 3'd0, st(0,0,0,0), "R8 mode load all idle");
        issue  (C_ACT, 2'd2, 11'h3FF, 3'd1, st(0,0,0,0), "R9 activate inside tMRD");
        issue_r(C_ACT, 2'd2, 11'h3FF, 3'd0, st(0,1,0,0), 2, 11'h3FF, "R9 activate after tMRD");
        issue  (C_ACT, 2'd3, 11'h005, 3'd0, st(1,1,0,0), "R2 activate bank3");
        issue  (C_PRE, 2'd1, 11'h000, 3'd0, st(1,1,0,0), "R6 precharge idle bank");
        issue  (C_PRE, 2'd2, 11'h000, 3'd0, st(1,3,0,0), "R5 single-bank precharge");
        issue  (C_WR,  2'd2, 11'h000, 3'd2, st(1,3,0,0), "R7 write inside tRP");
        cfg_burst_len = 4'd8;
        issue  (C_RD,  2'd3, 11'h100, 3'd0, st(2,3,0,0), "R12 R4 BL8 read with auto precharge");
        issue  (C_NOP, 2'd0, 11'h000, 3'd0, st(2,0,0,0), "R4 BL8 burst cycle 2");
        issue  (C_NOP, 2'd0, 11'h000, 3'd0, st(2,0,0,0), "R4 BL8 burst cycle 3");
        issue  (C_NOP, 2'd0, 11'h000, 3'd0, st(2,0,0,0), "R4 BL8 burst cycle 4");
        issue  (C_NOP, 2'd0, 11'h000, 3'd0, st(3,0,0,0), "R4 BL8 auto precharge");
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule